// File: doc/BRIEF.md
# Data Bus Buffer Enable Controller

This block is the glue between a 16-bit system data bus and a group of two to four graphics devices. Each device has its own output-enable line, and the block turns those lines into the enables of the bidirectional transceivers that join the devices' data ports to the system bus. Each device has two kinds of transceiver. A full-width "plane" buffer passes a whole 16-bit word. A 4-bit "pixel" buffer passes only that device's nibble of the word.

A single mode bit chooses which kind is used. The host sets the bit by running any bus cycle to one dedicated address and clears it with a cycle to a second address. The data and the read/write sense of that cycle do not matter. Every such cycle gets a data-transfer acknowledge from the block, so the bus never stalls on these addresses. Transceiver direction follows the system write line. While the DMA fly-by acknowledge of the data FIFO channel is active, that sense is inverted, because the device side then moves data opposite to the host's bus cycle.

Top module: `bus_buf_ctl`

## Requirements
- R1: After reset the mode bit `mode_pixel` is 0 (plane mode) and `xfer_ack` is 0.
- R2: At a clock edge where `bus_strobe` is 1, `xfer_ack` is 0 and `bus_addr` equals `SET_ADDR`, the mode bit becomes 1 (pixel mode). At such an edge with `bus_addr` equal to `CLR_ADDR`, it becomes 0. `bus_write` has no effect on this update.
- R3: `xfer_ack` goes to 1 at the first clock edge that samples `bus_strobe` high with a mode address. It stays 1 while the strobe is held and returns to 0 at the first edge that samples the strobe low.
- R4: A strobe to any other address leaves `xfer_ack` at 0 and leaves the mode bit unchanged.
- R5: `to_dev` (1 = system bus towards device, 0 = device towards system bus) equals `bus_write` while `fly_ack` is 0 and the inverse of `bus_write` while `fly_ack` is 1.
- R6: In plane mode `plane_en[k]` equals `dev_oe[k]` for every device, and all of `lane_en` is 0.
- R7: In pixel mode `lane_en[k]` equals `dev_oe[k]` for k below `NDEV`, and `plane_en` is all 0. Lane k is the buffer for data bits [4k+3:4k]. Lanes at or above `NDEV` stay 0.
- R8: With every `dev_oe` line at 0, all of `plane_en` and `lane_en` are 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_strobe | input | 1 | Bus cycle address strobe, active high |
| bus_addr | input | AW | Bus address |
| bus_write | input | 1 | 1 when the host writes |
| fly_ack | input | 1 | DMA fly-by acknowledge of the data FIFO channel |
| dev_oe | input | NDEV | Per-device output enable, active high |
| mode_pixel | output | 1 | Mode bit: 1 pixel, 0 plane |
| xfer_ack | output | 1 | Data-transfer acknowledge for mode-address cycles |
| to_dev | output | 1 | Transceiver direction |
| plane_en | output | NDEV | Full-width plane buffer enables |
| lane_en | output | 4 | Nibble pixel buffer enables, lane k = bits [4k+3:4k] |

## Verification
On every cycle the assertions check three things. They check the acknowledge timing relative to the strobe and the way the mode bit responds to the set, clear and other addresses. They check that plane and pixel enables are never active together. They also check that no enable is active without a device output-enable.

Some behaviour only the bench scenarios can show. These are the exact mapping from each output-enable pattern to a lane, the direction table over all write and fly-by combinations, and the fact that `bus_write` does not matter during mode accesses. They also include the silence of the lanes above the device count, which the bench shows with a second, two-device instance.

// File: rtl/bus_buf_ctl.sv
module bus_buf_ctl #(
  parameter int NDEV = 2,
  parameter int AW = 8,
  parameter logic [AW-1:0] SET_ADDR = 8'hF0,
  parameter logic [AW-1:0] CLR_ADDR = 8'hF1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_strobe,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_write,
  input  logic            fly_ack,
  input  logic [NDEV-1:0] dev_oe,
  output logic            mode_pixel,
  output logic            xfer_ack,
  output logic            to_dev,
  output logic [NDEV-1:0] plane_en,
  output logic [3:0]      lane_en
);
  localparam int LANES = 4;

  logic hit_set, hit_clr, hit;
  assign hit_set = (bus_addr == SET_ADDR);
  assign hit_clr = (bus_addr == CLR_ADDR);
  assign hit     = hit_set | hit_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_ack   <= 1'b0;
      mode_pixel <= 1'b0;
    end else begin
      xfer_ack <= bus_strobe & hit;
      if (bus_strobe && hit && !xfer_ack)
        mode_pixel <= hit_set;
    end
  end

  assign to_dev   = bus_write ^ fly_ack;
  assign plane_en = mode_pixel ? '0 : dev_oe;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j < NDEV) begin : g_used
      assign lane_en[j] = mode_pixel & dev_oe[j];
    end else begin : g_unused
      assign lane_en[j] = 1'b0;
    end
  end
endmodule

// File: rtl/bus_buf_ctl_chk.sv
module bus_buf_ctl_chk #(
  parameter int NDEV = 2,
  parameter int AW = 8,
  parameter logic [AW-1:0] SET_ADDR = 8'hF0,
  parameter logic [AW-1:0] CLR_ADDR = 8'hF1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_strobe,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_write,
  input logic            fly_ack,
  input logic [NDEV-1:0] dev_oe,
  input logic            mode_pixel,
  input logic            xfer_ack,
  input logic            to_dev,
  input logic [NDEV-1:0] plane_en,
  input logic [3:0]      lane_en
);
  logic is_mode_addr;
  assign is_mode_addr = (bus_addr == SET_ADDR) || (bus_addr == CLR_ADDR);

  p_ack_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && is_mode_addr) |=> xfer_ack);
  p_ack_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe |=> !xfer_ack);
  p_no_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !is_mode_addr) |=> !xfer_ack);
  p_mode_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !xfer_ack && bus_addr == SET_ADDR) |=> mode_pixel);
  p_mode_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && !xfer_ack && bus_addr == CLR_ADDR) |=> !mode_pixel);
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_strobe && is_mode_addr) |=> $stable(mode_pixel));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !((|plane_en) && (|lane_en)));
  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_oe == '0) |-> (plane_en == '0 && lane_en == '0));
endmodule

bind bus_buf_ctl bus_buf_ctl_chk #(.NDEV(NDEV), .AW(AW), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_chk (.*);

// File: tb/bus_buf_ctl_tb.sv
module bus_buf_ctl_tb;
  localparam logic [7:0] SA = 8'hF0;
  localparam logic [7:0] CA = 8'hF1;

  logic clk = 0, rst_n = 0, strobe = 0, wr = 0, fly = 0;
  logic [7:0] addr = 0;
  logic [3:0] oe = 0;
  logic mode, ack, dir, mode2, ack2, dir2;
  logic [3:0] pen, lane, lane2;
  logic [1:0] pen2;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  bus_buf_ctl #(.NDEV(4), .AW(8), .SET_ADDR(SA), .CLR_ADDR(CA)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_strobe(strobe), .bus_addr(addr), .bus_write(wr),
    .fly_ack(fly), .dev_oe(oe), .mode_pixel(mode), .xfer_ack(ack), .to_dev(dir),
    .plane_en(pen), .lane_en(lane));

  bus_buf_ctl #(.NDEV(2), .AW(8), .SET_ADDR(SA), .CLR_ADDR(CA)) u_small (
    .clk(clk), .rst_n(rst_n), .bus_strobe(strobe), .bus_addr(addr), .bus_write(wr),
    .fly_ack(fly), .dev_oe(oe[1:0]), .mode_pixel(mode2), .xfer_ack(ack2), .to_dev(dir2),
    .plane_en(pen2), .lane_en(lane2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mode_cycle(input logic [7:0] a, input logic w, input logic exp_mode);
    bit h;
    h = (a == SA) || (a == CA);
    @(negedge clk); strobe = 1; addr = a; wr = w;
    @(negedge clk);
    chk(ack == h, "R3 ack rise", ack, h);
    chk(mode == exp_mode, "R2 mode update", mode, exp_mode);
    @(negedge clk);
    chk(ack == h, "R3 ack hold", ack, h);
    chk(mode == exp_mode, "R2 mode stable", mode, exp_mode);
    strobe = 0;
    @(negedge clk);
    chk(ack == 0, "R3 ack drop", ack, 0);
  endtask

  task automatic sweep_comb(input logic m);
    for (int o = 0; o < 16; o++) begin
      for (int wf = 0; wf < 4; wf++) begin
        oe = o[3:0]; wr = wf[0]; fly = wf[1];
        #1;
        chk(dir == (wf[0] ^ wf[1]), "R5 direction", dir, wf[0] ^ wf[1]);
        chk(pen == (m ? 4'h0 : o[3:0]), "R6 plane enables", pen, m ? 0 : o);
        chk(lane == (m ? o[3:0] : 4'h0), "R7 lane enables", lane, m ? o : 0);
        chk(lane2 == (m ? {2'b00, o[1:0]} : 4'h0), "R7 unused lanes", lane2, m ? o[1:0] : 0);
        chk(pen2 == (m ? 2'b00 : o[1:0]), "R6 small plane", pen2, m ? 0 : o[1:0]);
        if (o == 0)
          chk(pen == 0 && lane == 0, "R8 idle", {pen, lane}, 0);
      end
    end
    oe = 0; wr = 0; fly = 0;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mode == 0, "R1 reset mode", mode, 0);
    chk(ack == 0, "R1 reset ack", ack, 0);
    sweep_comb(0);
    mode_cycle(SA, 0, 1);
    sweep_comb(1);
    mode_cycle(CA, 1, 0);
    mode_cycle(SA, 1, 1);
    mode_cycle(SA, 0, 1);
    for (int a = 0; a < 256; a++) begin
      if (a[7:0] != SA && a[7:0] != CA) mode_cycle(a[7:0], a[0], 1);
    end
    mode_cycle(CA, 0, 0);
    for (int a = 0; a < 256; a += 7) begin
      if (a[7:0] != SA && a[7:0] != CA) mode_cycle(a[7:0], 1, 0);
    end
    chk(mode2 == 0, "R2 small instance mode", mode2, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule